// File: doc/BRIEF.md
# I2C Serial Clock Generator with Prescaler

This block produces the timing of the I2C serial clock from the system clock. A programmable prescaler first turns the system clock into a slower module-clock tick, one tick every `psc + 1` system cycles. The low and high phases of SCL are each counted in module-clock ticks. Each phase lasts its programmed count plus a fixed offset, and the prescaler setting picks that offset.

On enable the generator starts a low phase, so it requests SCL driven low. It then alternates between low and high phases for as long as the enable stays set. A target on the bus can stretch the clock: the high phase does not advance while the sampled SCL line still reads low. Two one-cycle strobes mark the moment each phase hands over to the next. Clearing the enable releases SCL and returns every counter to its start value.

The divider inputs are assumed to change only while the enable is clear. Start and stop conditions and data shifting belong to neighbouring blocks.

Top module: `scl_clkgen`

## Requirements
- R1: The module-clock tick occurs once every `psc + 1` system cycles, so every phase length scales by `psc + 1`.
- R2: The phase offset d is 7 when `psc` is 0, 6 when `psc` is 1, and 5 when `psc` is 2 or more (with `fix_offset` = 0).
- R3: When `fix_offset` = 1 the offset d is 6 for every `psc` value.
- R4: `scl_low` rises on the cycle after the first clock edge that samples `en` = 1 from the disabled state. It then stays 1 for exactly `(low_cnt + d) * (psc + 1)` system cycles.
- R5: With `scl_in` = 1 throughout, the high phase (`scl_low` = 0 while enabled) lasts exactly `(high_cnt + d) * (psc + 1)` system cycles. A `high_cnt` of 0 is legal and gives d module clocks.
- R6: A module-clock tick in the high phase whose sampled `scl_in` is 0 does not advance the high count. With `psc` = 0, S such edges lengthen the high phase by exactly S cycles, and the high phase never ends while `scl_in` is 0.
- R7: A clock edge that samples `en` = 0 makes `scl_low` 0 from the next cycle. A later enable starts a full-length low phase again.
- R8: `low_tick` is 1 for exactly the first system cycle of each high phase. `high_tick` is 1 for exactly the first system cycle of each low phase that follows a high phase. The two are never 1 together.
- R9: After reset, `scl_low`, `low_tick` and `high_tick` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run the clock generator; 0 releases SCL and clears counters |
| psc | input | PSC_W | Prescaler setting; module tick every psc+1 cycles |
| low_cnt | input | CNT_W | Programmed low-phase count |
| high_cnt | input | CNT_W | Programmed high-phase count |
| fix_offset | input | 1 | 1 forces the phase offset to 6 |
| scl_in | input | 1 | Sampled SCL line level, used for stretching |
| scl_low | output | 1 | Request to drive SCL low |
| low_tick | output | 1 | One-cycle strobe at the start of each high phase |
| high_tick | output | 1 | One-cycle strobe at the start of each low phase after a high phase |

## Verification
`scl_low` is due on the cycle after the edge that first samples the enable. It drops on the cycle after an edge that samples the enable clear. Each strobe shows in the same cycle as the phase change it marks, because strobe and phase come from the same edge. The bench drives all inputs on falling edges and reads outputs on falling edges. It counts falling edges with `scl_low` at each level and compares them with `(count + d) * (psc + 1)` from its own offset function. It reads the strobes on the first falling edge of the new phase. Stretch cases run with `psc` = 0, so every held edge adds exactly one cycle.

// File: rtl/scl_clkgen_pkg.sv
// Shared types for the SCL clock generator.
package scl_clkgen_pkg;

    // Phase of the generated serial clock.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } scl_phase_t;

    // Width of the phase offset value.
    localparam int OFS_W = 3;

endpackage

// File: rtl/scl_prescaler.sv
// Prescaler: emits a one-cycle module-clock tick every psc+1 system cycles
// while run is set. Assumes psc is stable while run is set; the count
// returns to zero whenever run is clear.
module scl_prescaler #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PSC_W-1:0] psc,
    output logic             mtick
);
    logic [PSC_W-1:0] div_q;

    // Tick on the last count of each prescaler period.
    always_comb mtick = run && (div_q == psc);

    // Advance the prescaler count, wrapping on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            div_q <= '0;
        end else if (mtick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end
endmodule

// File: rtl/scl_offset_sel.sv
// Offset selector: picks the fixed extension added to each SCL phase.
// It is 7, 6 or 5 for a prescaler of 0, 1, or 2 and above. A forced mode
// gives 6 always. Purely combinational.
module scl_offset_sel #(
    parameter int PSC_W = 8
) (
    input  logic                             [PSC_W-1:0] psc,
    input  logic                                         fix_offset,
    output logic [scl_clkgen_pkg::OFS_W-1:0]             ofs
);
    // Choose the offset from the prescaler setting.
    always_comb begin
        if (fix_offset) begin
            ofs = 3'd6;
        end else if (psc == '0) begin
            ofs = 3'd7;
        end else if (psc == PSC_W'(1)) begin
            ofs = 3'd6;
        end else begin
            ofs = 3'd5;
        end
    end
endmodule

// File: rtl/scl_phase_timer.sv
// Phase timer: alternates SCL low and high phases, each lasting its
// programmed count plus the offset, counted in module ticks. The high
// count holds while the sampled line reads low (clock stretching).
// Assumes counts and offset are stable while en is set.
module scl_phase_timer
    import scl_clkgen_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             mtick,
    input  logic [CNT_W-1:0] low_cnt,
    input  logic [CNT_W-1:0] high_cnt,
    input  logic [OFS_W-1:0] ofs,
    input  logic             scl_in,
    output logic             run,
    output logic             scl_low,
    output logic             low_tick,
    output logic             high_tick
);
    localparam int LEN_W = CNT_W + 1;

    scl_phase_t       phase_q;
    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] low_last;
    logic [LEN_W-1:0] high_last;
    logic             low_end;
    logic             high_end;
    logic             low_tick_q;
    logic             high_tick_q;

    // Last tick index of each phase: count plus offset, minus one.
    always_comb begin
        low_last  = LEN_W'(low_cnt)  + LEN_W'(ofs) - 1'b1;
        high_last = LEN_W'(high_cnt) + LEN_W'(ofs) - 1'b1;
    end

    // Detect the final module tick of the current phase.
    always_comb begin
        low_end  = en && (phase_q == PH_LOW)  && mtick && (cnt_q == low_last);
        high_end = en && (phase_q == PH_HIGH) && mtick && scl_in
                   && (cnt_q == high_last);
    end

    // Step the phase state and the in-phase tick counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    phase_q <= PH_LOW;
                    cnt_q   <= '0;
                end
                PH_LOW: begin
                    if (low_end) begin
                        phase_q <= PH_HIGH;
                        cnt_q   <= '0;
                    end else if (mtick) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (high_end) begin
                        phase_q <= PH_LOW;
                        cnt_q   <= '0;
                    end else if (mtick && scl_in) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    phase_q <= PH_IDLE;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    // Register the phase hand-over strobes so they align with the new phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_tick_q  <= 1'b0;
            high_tick_q <= 1'b0;
        end else begin
            low_tick_q  <= low_end;
            high_tick_q <= high_end;
        end
    end

    // Drive outputs from registered state.
    always_comb begin
        run       = (phase_q != PH_IDLE) && en;
        scl_low   = (phase_q == PH_LOW);
        low_tick  = low_tick_q;
        high_tick = high_tick_q;
    end
endmodule

// File: rtl/scl_clkgen.sv
// SCL clock generator top: prescaler, offset selector and phase timer.
// Assumes psc, low_cnt, high_cnt and fix_offset change only while en is 0.
module scl_clkgen #(
    parameter int PSC_W = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [PSC_W-1:0] psc,
    input  logic [CNT_W-1:0] low_cnt,
    input  logic [CNT_W-1:0] high_cnt,
    input  logic             fix_offset,
    input  logic             scl_in,
    output logic             scl_low,
    output logic             low_tick,
    output logic             high_tick
);
    logic                              mtick;
    logic                              run;
    logic [scl_clkgen_pkg::OFS_W-1:0]  ofs;

    scl_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .psc   (psc),
        .mtick (mtick)
    );

    scl_offset_sel #(.PSC_W(PSC_W)) u_ofs (
        .psc        (psc),
        .fix_offset (fix_offset),
        .ofs        (ofs)
    );

    scl_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .mtick     (mtick),
        .low_cnt   (low_cnt),
        .high_cnt  (high_cnt),
        .ofs       (ofs),
        .scl_in    (scl_in),
        .run       (run),
        .scl_low   (scl_low),
        .low_tick  (low_tick),
        .high_tick (high_tick)
    );
endmodule

// File: rtl/scl_clkgen_chk.sv
// Checker for the SCL clock generator, bound to every instance of the top.
module scl_clkgen_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic scl_in,
    input logic scl_low,
    input logic low_tick,
    input logic high_tick
);
    // R7: a sampled disable releases SCL on the next cycle.
    a_r7_release_on_disable: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !scl_low);

    // R4: the first enabled edge starts a low phase.
    a_r4_low_on_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !$past(en)) |=> scl_low);

    // R8: low_tick marks the first cycle of a high phase.
    a_r8_low_tick_edge: assert property (@(posedge clk) disable iff (!rst_n)
        low_tick |-> (!scl_low && $past(scl_low)));

    // R8: high_tick marks the first cycle of a low phase.
    a_r8_high_tick_edge: assert property (@(posedge clk) disable iff (!rst_n)
        high_tick |-> (scl_low && !$past(scl_low)));

    // R8: the two strobes are exclusive.
    a_r8_tick_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({low_tick, high_tick}));

    // R6: a high phase cannot end while the line is held low.
    a_r6_stretch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && en && !scl_low && !scl_in) |=> !scl_low);
endmodule

bind scl_clkgen scl_clkgen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .scl_in    (scl_in),
    .scl_low   (scl_low),
    .low_tick  (low_tick),
    .high_tick (high_tick)
);

// File: tb/test_scl_clkgen.sv
// Self-checking bench for scl_clkgen: directed corners plus seeded random.
module test_scl_clkgen;
    localparam int CLK_PERIOD = 10;
    localparam int PSC_W = 8;
    localparam int CNT_W = 16;
    localparam int LIM = 5000;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             en;
    logic [PSC_W-1:0] psc;
    logic [CNT_W-1:0] low_cnt;
    logic [CNT_W-1:0] high_cnt;
    logic             fix_offset;
    logic             scl_in;
    logic             scl_low;
    logic             low_tick;
    logic             high_tick;

    int checks = 0;
    int errors = 0;

    scl_clkgen #(.PSC_W(PSC_W), .CNT_W(CNT_W)) i_scl_clkgen (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .psc        (psc),
        .low_cnt    (low_cnt),
        .high_cnt   (high_cnt),
        .fix_offset (fix_offset),
        .scl_in     (scl_in),
        .scl_low    (scl_low),
        .low_tick   (low_tick),
        .high_tick  (high_tick)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int exp_ofs(input int p, input bit fx);
        if (fx)     return 6;
        if (p == 0) return 7;
        if (p == 1) return 6;
        return 5;
    endfunction

    function automatic int exp_len(input int c, input int p, input bit fx);
        return (c + exp_ofs(p, fx)) * (p + 1);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Idle the block with the given settings, then enable it.
    task automatic start(input int p, input int l, input int h, input bit fx);
        @(negedge clk);
        en = 1'b0;
        scl_in = 1'b1;
        @(negedge clk);
        psc = PSC_W'(p);
        low_cnt = CNT_W'(l);
        high_cnt = CNT_W'(h);
        fix_offset = fx;
        @(negedge clk);
        en = 1'b1;
    endtask

    // Measure one low phase, the following high phase (with optional
    // stretch of s edges at its start), and check the strobes.
    task automatic measure(input int p, input int l, input int h, input bit fx,
                           input int s, input string tag);
        int lo = 0;
        int hi = 0;
        int exp_hi;
        @(negedge clk);
        check(scl_low == 1'b1, {tag, " R4 start"}, int'(scl_low), 1);
        while (scl_low && lo < LIM) begin
            lo++;
            @(negedge clk);
        end
        check(lo == exp_len(l, p, fx), {tag, " R4/R1/R2/R3 low length"}, lo, exp_len(l, p, fx));
        check(low_tick && !high_tick, {tag, " R8 low_tick"}, int'(low_tick), 1);
        while (!scl_low && hi < LIM) begin
            if (hi == 0 && s > 0) scl_in = 1'b0;
            if (hi == s) scl_in = 1'b1;
            hi++;
            @(negedge clk);
        end
        scl_in = 1'b1;
        exp_hi = exp_len(h, p, fx) + s;
        check(hi == exp_hi, {tag, " R5/R6 high length"}, hi, exp_hi);
        check(high_tick && !low_tick, {tag, " R8 high_tick"}, int'(high_tick), 1);
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd4242);
        rst_n = 1'b0;
        en = 1'b0;
        psc = '0;
        low_cnt = '0;
        high_cnt = '0;
        fix_offset = 1'b0;
        scl_in = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        check(!scl_low && !low_tick && !high_tick, "R9 reset outputs",
              int'({scl_low, low_tick, high_tick}), 0);

        // R2: offset table, directed
        start(0, 3, 2, 1'b0); measure(0, 3, 2, 1'b0, 0, "psc0");
        start(1, 4, 1, 1'b0); measure(1, 4, 1, 1'b0, 0, "psc1");
        start(2, 2, 5, 1'b0); measure(2, 2, 5, 1'b0, 0, "psc2");
        start(5, 1, 1, 1'b0); measure(5, 1, 1, 1'b0, 0, "psc5");
        // R3: forced offset
        start(0, 3, 3, 1'b1); measure(0, 3, 3, 1'b1, 0, "fix0");
        start(3, 2, 0, 1'b1); measure(3, 2, 0, 1'b1, 0, "fix3");
        // R5: zero counts give d-length phases
        start(0, 0, 0, 1'b0); measure(0, 0, 0, 1'b0, 0, "zero");
        // R6: stretch
        start(0, 2, 3, 1'b0); measure(0, 2, 3, 1'b0, 4, "stretch4");
        start(0, 1, 0, 1'b0); measure(0, 1, 0, 1'b0, 9, "stretch9");

        // R7: disable mid low phase, then a full restart
        start(1, 6, 2, 1'b0);
        repeat (5) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        check(!scl_low, "R7 release after disable", int'(scl_low), 0);
        repeat (3) @(negedge clk);
        check(!scl_low && !low_tick && !high_tick, "R7 stays idle",
              int'({scl_low, low_tick, high_tick}), 0);
        en = 1'b1;
        measure(1, 6, 2, 1'b0, 0, "restart");

        // R7: disable during high phase
        start(0, 1, 10, 1'b0);
        @(negedge clk);
        while (scl_low) @(negedge clk);
        repeat (3) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        check(!scl_low && !low_tick && !high_tick, "R7 idle after high disable",
              int'({scl_low, low_tick, high_tick}), 0);
        en = 1'b1;
        measure(0, 1, 10, 1'b0, 0, "restart_hi");

        // Random configurations
        for (int i = 0; i < 20; i++) begin
            int p  = int'($urandom_range(0, 3));
            int l  = int'($urandom_range(0, 20));
            int h  = int'($urandom_range(0, 20));
            bit fx = bit'($urandom_range(0, 1));
            int s  = (p == 0) ? int'($urandom_range(0, 6)) : 0;
            start(p, l, h, fx);
            measure(p, l, h, fx, s, "random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule